// File: doc/BRIEF.md
# USB Full/Low-Speed Line State Qualifier

This block serves one port of a USB 1.1 repeater. It takes the transceiver's three receive signals (the differential receiver output and the two single-ended line comparators) and turns them into one clean line symbol: J, K or single-ended zero (SE0). Changes of the differential receiver are taken at once, because a repeater must follow data edges with no added delay. A short dip of both lines low, which appears naturally while the pair swings between J and K, is not reported as SE0. Both lines must stay low for a persistence window before SE0 is accepted. The window is long at low-speed edge rates and short once a full-speed packet is known to be in progress.

The surrounding repeater tells the block which window applies, through a full-speed flag. It also raises a hold input while this port is being driven from the other side, so that the block's own echo is never taken for an SE0 from the far end. The block outputs the qualified symbol, a one-cycle pulse on every symbol change, and a count of how long SE0 has lasted. The repeater uses that count to tell reset and disconnect apart from an end of packet. All windows are written in nanoseconds and converted to clock cycles from a clock-frequency parameter. At the default of 250 MHz, low-speed SE0 takes 53 cycles, full-speed SE0 takes 4 cycles, the SE0 exit takes 11 cycles and the receiver lockout takes 11 cycles.

Top module: `usb_line_qual`

## Requirements
- R1: The three line inputs pass through a two-flop synchronizer. From J or K, a change of `rcvIn` sets `lineState` to the matching symbol on the third rising edge after the change, with no qualification delay. `rcvIn` high means J and `rcvIn` low means K. `lineState` is encoded as 2'b00 SE0, 2'b01 J and 2'b10 K.
- R2: After a J/K change is registered, further changes of `rcvIn` are ignored for LOCK cycles (11 at default). The level present after that is then taken.
- R3: With `fsPacket` low, SE0 is entered only after `vpIn` and `vmIn` are both low for 53 consecutive synchronized samples. A shorter low run leaves the symbol unchanged.
- R4: With `fsPacket` high, SE0 is entered after 4 consecutive synchronized low samples of both lines.
- R5: SE0 is left only after `vpIn` or `vmIn` is high for 11 consecutive synchronized samples. The symbol then always becomes J, whatever `rcvIn` shows. Shorter high runs keep SE0.
- R6: `vpIn` and `vmIn` both high is never treated as SE0. `rcvIn` alone selects J or K.
- R7: `se0Count` equals the number of consecutive synchronized samples with both lines low. It returns to 0 once a sample with either line high reaches it.
- R8: While `holdClear` is high, `se0Count` is 0 one edge later and SE0 cannot be qualified.
- R9: `se0Count` saturates at 2^CNT_W-1 (255 at default) and never wraps.
- R10: During and right after reset, `lineState` is SE0, `se0Count` is 0 and `lineChange` is 0.
- R11: `lineChange` is high for exactly the one cycle that follows each edge at which `lineState` changes, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rcvIn | input | 1 | Differential receiver output from the transceiver |
| vpIn | input | 1 | Single-ended comparator on the positive line |
| vmIn | input | 1 | Single-ended comparator on the negative line |
| fsPacket | input | 1 | A full-speed packet is in progress (selects the short SE0 window) |
| holdClear | input | 1 | This port is being driven by the opposite port |
| lineState | output | 2 | Qualified symbol: 00 SE0, 01 J, 10 K |
| lineChange | output | 1 | One-cycle pulse on each change of lineState |
| se0Count | output | CNT_W | Saturating count of consecutive SE0 samples |

## Verification
A J/K change at the pins shows on `lineState` three edges later: two synchronizer flops and the state register. SE0 entry comes threshold+3 edges after the lines fall, and SE0 exit comes 11+3 edges after a line rises. `se0Count` lags the synchronized lines by one edge, so it reads k-2 after k edges of SE0. The bench drives inputs on the falling edge and samples 1 ns after a chosen rising edge. Directed checks sit one edge before and at the edge where each change is due. A cycle-level bench model, built from these latencies, is also compared with every output at every falling edge during a seeded random phase.

// File: rtl/usb_line_pkg.sv
package usb_line_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10
  } lineSym_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLock;
    logic clearLock;
  } ctrlStrobe_t;

  // qualified conditions from datapath to control
  typedef struct packed {
    logic rcvSync;
    logic se0Qual;
    logic exitQual;
    logic lockBusy;
  } dpStatus_t;

  function automatic int nsToCycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/usb_line_dp.sv
module usb_line_dp
  import usb_line_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LS_CYC   = 53,
  parameter int FS_CYC   = 4,
  parameter int EXIT_CYC = 11,
  parameter int LOCK_CYC = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rcvIn,
  input  logic             vpIn,
  input  logic             vmIn,
  input  logic             fsPacket,
  input  logic             holdClear,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic [CNT_W-1:0] se0Count
);

  localparam int NSYNC = 3;
  localparam int HI_W  = $clog2(EXIT_CYC + 1);
  localparam int LK_W  = $clog2(LOCK_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LS_THR  = CNT_W'(LS_CYC);
  localparam logic [CNT_W-1:0] FS_THR  = CNT_W'(FS_CYC);
  localparam logic [HI_W-1:0]  HI_MAX  = HI_W'(EXIT_CYC);
  localparam logic [LK_W-1:0]  LK_LOAD = LK_W'(LOCK_CYC);

  logic [NSYNC-1:0] rawIn, syncA, syncB;
  logic             se0Raw;
  logic [HI_W-1:0]  highCnt;
  logic [LK_W-1:0]  lockCnt;

  assign rawIn = {rcvIn, vpIn, vmIn};

  generate
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          syncA[g] <= 1'b0;
          syncB[g] <= 1'b0;
        end else begin
          syncA[g] <= rawIn[g];
          syncB[g] <= syncA[g];
        end
      end
    end
  endgenerate

  assign se0Raw = !syncB[1] && !syncB[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      se0Count <= '0;
      highCnt  <= '0;
      lockCnt  <= '0;
    end else begin
      if (holdClear || !se0Raw)    se0Count <= '0;
      else if (se0Count != CNT_MAX) se0Count <= se0Count + 1'b1;

      if (se0Raw)                highCnt <= '0;
      else if (highCnt != HI_MAX) highCnt <= highCnt + 1'b1;

      if (strobe.loadLock)       lockCnt <= LK_LOAD;
      else if (strobe.clearLock) lockCnt <= '0;
      else if (lockCnt != '0)    lockCnt <= lockCnt - 1'b1;
    end
  end

  assign status.rcvSync  = syncB[2];
  assign status.se0Qual  = se0Count >= (fsPacket ? FS_THR : LS_THR);
  assign status.exitQual = highCnt == HI_MAX;
  assign status.lockBusy = lockCnt != '0;

  // R7: a line seen high clears the duration count
  a_r7_clear_on_high: assert property (@(posedge clk) disable iff (!rstN)
    !se0Raw |=> se0Count == '0);
  // R8: the hold input forces the count to zero
  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    holdClear |=> se0Count == '0);
  // R9: a saturated count stays saturated while SE0 lasts
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (se0Count == CNT_MAX && se0Raw && !holdClear) |=> se0Count == CNT_MAX);

endmodule

// File: rtl/usb_line_ctrl.sv
module usb_line_ctrl
  import usb_line_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output lineSym_t    lineSym,
  output logic        lineChange
);

  lineSym_t nxtSym, rcvSym;

  assign rcvSym = status.rcvSync ? LINE_J : LINE_K;

  always_comb begin
    nxtSym = lineSym;
    strobe = '0;
    if (lineSym == LINE_SE0) begin
      if (status.exitQual) nxtSym = LINE_J;
    end else if (status.se0Qual) begin
      nxtSym          = LINE_SE0;
      strobe.clearLock = 1'b1;
    end else if (!status.lockBusy && rcvSym != lineSym) begin
      nxtSym          = rcvSym;
      strobe.loadLock = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineSym    <= LINE_SE0;
      lineChange <= 1'b0;
    end else begin
      lineSym    <= nxtSym;
      lineChange <= nxtSym != lineSym;
    end
  end

  // R11: every symbol change is flagged
  a_r11_change_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym != $past(lineSym)) |-> lineChange);
  // R5: leaving SE0 never lands on K
  a_r5_exit_to_j: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym == LINE_SE0) |=> lineSym != LINE_K);
  // R2: no J/K change while the receiver lockout runs
  a_r2_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym != LINE_SE0 && status.lockBusy && !status.se0Qual) |=> $stable(lineSym));
  // R3: SE0 is never entered without a qualified window
  a_r3_se0_needs_window: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym != LINE_SE0 && !status.se0Qual) |=> lineSym != LINE_SE0);

endmodule

// File: rtl/usb_line_qual.sv
module usb_line_qual
  import usb_line_pkg::*;
#(
  parameter int CLK_MHZ   = 250,
  parameter int LS_SE0_NS = 210,
  parameter int FS_SE0_NS = 14,
  parameter int EXIT_NS   = 41,
  parameter int LOCK_NS   = 41,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rcvIn,
  input  logic             vpIn,
  input  logic             vmIn,
  input  logic             fsPacket,
  input  logic             holdClear,
  output logic [1:0]       lineState,
  output logic             lineChange,
  output logic [CNT_W-1:0] se0Count
);

  localparam int LS_CYC   = nsToCycles(LS_SE0_NS, CLK_MHZ);
  localparam int FS_CYC   = nsToCycles(FS_SE0_NS, CLK_MHZ);
  localparam int EXIT_CYC = nsToCycles(EXIT_NS, CLK_MHZ);
  localparam int LOCK_CYC = nsToCycles(LOCK_NS, CLK_MHZ);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  lineSym_t    lineSym;

  usb_line_dp #(
    .CNT_W(CNT_W), .LS_CYC(LS_CYC), .FS_CYC(FS_CYC),
    .EXIT_CYC(EXIT_CYC), .LOCK_CYC(LOCK_CYC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .rcvIn(rcvIn), .vpIn(vpIn), .vmIn(vmIn),
    .fsPacket(fsPacket), .holdClear(holdClear), .strobe(strobe),
    .status(status), .se0Count(se0Count)
  );

  usb_line_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .strobe(strobe),
    .lineSym(lineSym), .lineChange(lineChange)
  );

  assign lineState = lineSym;

endmodule

// File: tb/test_usb_line_qual.sv
module test_usb_line_qual;

  localparam int MHZ   = 250;
  localparam int LS    = (210 * MHZ + 999) / 1000;
  localparam int FS    = (14 * MHZ + 999) / 1000;
  localparam int EXIT  = (41 * MHZ + 999) / 1000;
  localparam int LOCK  = (41 * MHZ + 999) / 1000;
  localparam int CMAX  = 255;

  logic clk = 1'b0, rstN = 1'b0;
  logic rcvIn = 1'b1, vpIn = 1'b1, vmIn = 1'b0, fsPacket = 1'b0, holdClear = 1'b0;
  logic [1:0] lineState;
  logic lineChange;
  logic [7:0] se0Count;

  int checks = 0, fails = 0;
  bit done = 0;
  string curReq = "R10";

  always #2 clk = ~clk;

  usb_line_qual i_usb_line_qual (
    .clk(clk), .rstN(rstN), .rcvIn(rcvIn), .vpIn(vpIn), .vmIn(vmIn),
    .fsPacket(fsPacket), .holdClear(holdClear), .lineState(lineState),
    .lineChange(lineChange), .se0Count(se0Count)
  );

  // cycle-level model of the requirements
  int mState = 0, mCnt = 0, mHigh = 0, mLock = 0;
  bit mChange = 0, mRcv1 = 0, mRcv2 = 0, mVp1 = 0, mVp2 = 0, mVm1 = 0, mVm2 = 0;

  function automatic int rcvSym(bit r);
    return r ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mHigh = 0; mLock = 0; mChange = 0;
      mRcv1 = 0; mRcv2 = 0; mVp1 = 0; mVp2 = 0; mVm1 = 0; mVm2 = 0;
    end else begin
      bit se0, ld, clr;
      int nxt;
      se0 = !mVp2 && !mVm2;
      nxt = mState; ld = 0; clr = 0;
      if (mState == 0) begin
        if (mHigh >= EXIT) nxt = 1;
      end else if (mCnt >= (fsPacket ? FS : LS)) begin
        nxt = 0; clr = 1;
      end else if (mLock == 0 && rcvSym(mRcv2) != mState) begin
        nxt = rcvSym(mRcv2); ld = 1;
      end
      mChange = (nxt != mState);
      mState  = nxt;
      mCnt  = (holdClear || !se0) ? 0 : ((mCnt == CMAX) ? CMAX : mCnt + 1);
      mHigh = se0 ? 0 : ((mHigh >= EXIT) ? EXIT : mHigh + 1);
      mLock = ld ? LOCK : (clr ? 0 : ((mLock > 0) ? mLock - 1 : 0));
      mRcv2 = mRcv1; mRcv1 = rcvIn;
      mVp2 = mVp1;   mVp1 = vpIn;
      mVm2 = mVm1;   mVm1 = vmIn;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // continuous comparison with the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, "model lineState", lineState, mState);
      check("R11", "model lineChange", lineChange, mChange);
      check(curReq, "model se0Count", se0Count, mCnt);
    end
  end

  task automatic drive(bit r, bit p, bit m);
    @(negedge clk);
    rcvIn = r; vpIn = p; vmIn = m;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    // R10 reset state
    edges(3);
    check("R10", "reset lineState", lineState, 0);
    check("R10", "reset se0Count", se0Count, 0);
    check("R10", "reset lineChange", lineChange, 0);
    @(negedge clk); rstN = 1'b1;
    edges(1);
    check("R10", "post-reset lineState", lineState, 0);

    // R5 idle J leaves SE0
    curReq = "R5";
    edges(20);
    check("R5", "idle J", lineState, 1);

    // R1 and R11: J to K after three edges
    curReq = "R1";
    drive(0, 0, 1);
    edges(2);
    check("R1", "K not before third edge", lineState, 1);
    edges(1);
    check("R1", "K at third edge", lineState, 2);
    check("R11", "change pulse", lineChange, 1);

    // R2 lockout
    curReq = "R2";
    drive(1, 1, 0);
    edges(1);
    check("R11", "pulse one cycle", lineChange, 0);
    edges(10);
    check("R2", "K held in lockout", lineState, 2);
    edges(1);
    check("R2", "J after lockout", lineState, 1);
    edges(20);

    // R3 short low-speed SE0 ignored, R7 count
    curReq = "R3";
    drive(1, 0, 0);
    edges(40);
    check("R3", "short SE0 ignored", lineState, 1);
    check("R7", "count after 40 edges", se0Count, 38);
    drive(1, 1, 0);
    edges(3);
    check("R7", "count cleared", se0Count, 0);
    edges(20);
    drive(1, 0, 0);
    edges(55);
    check("R3", "SE0 not yet", lineState, 1);
    edges(1);
    check("R3", "SE0 accepted", lineState, 0);

    // R5 exit always J, then K follows
    curReq = "R5";
    drive(0, 1, 0);
    edges(3);
    drive(0, 0, 0);
    edges(20);
    check("R5", "short high keeps SE0", lineState, 0);
    drive(0, 0, 1);
    edges(13);
    check("R5", "SE0 held before exit", lineState, 0);
    edges(1);
    check("R5", "exit lands on J", lineState, 1);
    edges(1);
    check("R1", "K follows exit", lineState, 2);
    drive(1, 1, 0);
    edges(20);

    // R4 full-speed window
    curReq = "R4";
    fsPacket = 1'b1;
    drive(1, 0, 0);
    edges(3);
    drive(1, 1, 0);
    edges(10);
    check("R4", "3-sample dip ignored", lineState, 1);
    drive(1, 0, 0);
    edges(6);
    check("R4", "fs SE0 not yet", lineState, 1);
    edges(1);
    check("R4", "fs SE0 accepted", lineState, 0);
    fsPacket = 1'b0;
    drive(1, 1, 0);
    edges(20);

    // R6 both high is not SE0
    curReq = "R6";
    drive(0, 1, 1);
    edges(3);
    check("R6", "both high gives K", lineState, 2);
    check("R6", "both high count", se0Count, 0);
    edges(80);
    check("R6", "both high no SE0", lineState, 2);
    drive(1, 1, 0);
    edges(20);

    // R8 hold
    curReq = "R8";
    holdClear = 1'b1;
    drive(1, 0, 0);
    edges(100);
    check("R8", "held count", se0Count, 0);
    check("R8", "held no SE0", lineState, 1);
    holdClear = 1'b0;
    edges(60);
    check("R8", "SE0 after hold released", lineState, 0);

    // R9 saturation
    curReq = "R9";
    edges(300);
    check("R9", "saturated count", se0Count, CMAX);
    drive(1, 1, 0);
    edges(3);
    check("R7", "count cleared after saturation", se0Count, 0);
    edges(20);

    // seeded random phase
    curReq = "R1";
    begin
      int seed = $urandom(12345);
      bit r = 1;
      for (int seg = 0; seg < 300; seg++) begin
        int kind = $urandom_range(0, 9);
        int len  = $urandom_range(1, 90);
        fsPacket  = ($urandom_range(0, 1) == 1);
        holdClear = ($urandom_range(0, 7) == 0);
        if (kind < 3)      begin r = 1; drive(1, 1, 0); curReq = "R1"; end
        else if (kind < 6) begin r = 0; drive(0, 0, 1); curReq = "R2"; end
        else if (kind < 9) begin drive(r, 0, 0); curReq = "R3"; end
        else               begin r = $urandom_range(0, 1); drive(r, 1, 1); curReq = "R6"; end
        edges(len);
        if (seed == 0) seed = 1;
      end
    end
    edges(5);
    finishRun();
  end

endmodule